// File: doc/BRIEF.md
# E3 Frame-Master Serial Payload Source

This block is the system-side payload source for an E3 transmit framer that runs as a frame slave. The block and the framer share one 34.368 MHz transmit clock. The block marks the start of each frame with a one-clock reference strobe. It shifts payload out one bit per clock, and it stops shifting whenever the framer says the current bit period belongs to overhead.

Payload bytes arrive on a byte-wide ready/valid port. They wait in a small FIFO and are sent most significant bit first. Byte boundaries do not have to line up with frame boundaries. If the FIFO has no byte when the shifter needs one, the block sends a whole fill byte instead. This keeps the frame timing intact.

Top module: `e3_payload_master`

## Requirements
- R1: While `rst` is sampled high, the next clock edge leaves `ser_data` = 0, `frame_ref` = 0, the FIFO empty and `byte_ready` = 1.
- R2: An issue edge is a rising edge at which `rst` and `ovh_ind` are both sampled low. Each issue edge puts exactly one new payload bit on `ser_data`, and each byte is sent bit 7 first down to bit 0.
- R3: At an edge where `ovh_ind` is sampled high, `ser_data` keeps its value, `frame_ref` goes low, and no payload bit is consumed. This holds for any number of consecutive high samples.
- R4: `frame_ref` is high for exactly one clock, after the issue edge that sends payload bit 0 of a frame. The first such edge is the first issue edge after reset is released.
- R5: Consecutive `frame_ref` pulses are exactly `PAYLOAD_BITS` issue edges apart, whatever the byte alignment.
- R6: A byte is accepted at an edge where `byte_valid` and `byte_ready` are both high. An accepted byte can be loaded for sending from the next edge on. `byte_ready` is low exactly when `FIFO_DEPTH` bytes are stored.
- R7: If no stored byte is available when the shifter needs a new byte, all 8 bits of `FILL_BYTE` are sent, MSB first.
- R8: Accepted bytes are sent in acceptance order. None are lost or repeated, including while `byte_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared 34.368 MHz transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_data | input | 8 | Payload byte offered |
| byte_valid | input | 1 | Payload byte offered is valid |
| byte_ready | output | 1 | FIFO can take a byte |
| ovh_ind | input | 1 | Framer flags an overhead bit period |
| ser_data | output | 1 | Serial payload bit (registered) |
| frame_ref | output | 1 | One-clock frame start strobe (registered) |

## Verification
The properties assume that `ovh_ind` and `rst` are synchronous to `clk`. They also assume that `PAYLOAD_BITS` is at least 2, so two strobes can never be adjacent. The stimulus changes every input only on the falling edge. It uses a short frame so that strobe spacing is checked over many frames, and it produces overhead runs of length 1 and 16, a run at the first edge after reset, FIFO full and empty periods, and a reset in mid-frame. Under all of these the strobe stays single-cycle and the hold rule stays observable.

// File: rtl/e3m_pkg.sv
package e3m_pkg;
  typedef logic [7:0] e3m_byte_t;

  function automatic e3m_byte_t e3m_shift_left(input e3m_byte_t b);
    return {b[6:0], 1'b0};
  endfunction
endpackage

// File: rtl/e3m_byte_fifo.sv
module e3m_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push, pop;

  assign wr_ready = (count != CW'(DEPTH));
  assign empty    = (count == '0);
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_en && !empty;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/e3m_serializer.sv
module e3m_serializer
  import e3m_pkg::*;
#(
  parameter e3m_byte_t FILL_BYTE = 8'h55
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      advance,
  input  logic      src_empty,
  input  e3m_byte_t src_data,
  output logic      src_pop,
  output logic      ser_out
);
  e3m_byte_t  shreg;
  logic [2:0] left;
  logic       need;
  e3m_byte_t  load;

  assign need    = (left == 3'd0);
  assign src_pop = advance && need && !src_empty;
  assign load    = src_empty ? FILL_BYTE : src_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      left    <= '0;
      ser_out <= 1'b0;
    end else if (advance) begin
      if (need) begin
        ser_out <= load[7];
        shreg   <= e3m_shift_left(load);
        left    <= 3'd7;
      end else begin
        ser_out <= shreg[7];
        shreg   <= e3m_shift_left(shreg);
        left    <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/e3m_frame_ctr.sv
module e3m_frame_ctr #(
  parameter int PAYLOAD_BITS = 1524
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic frame_ref
);
  localparam int PW = (PAYLOAD_BITS > 1) ? $clog2(PAYLOAD_BITS) : 1;
  localparam logic [PW-1:0] LAST = PW'(PAYLOAD_BITS - 1);

  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      frame_ref <= 1'b0;
    end else if (advance) begin
      frame_ref <= (pos == '0);
      pos       <= (pos == LAST) ? '0 : pos + 1'b1;
    end else begin
      frame_ref <= 1'b0;
    end
  end
endmodule

// File: rtl/e3_payload_master.sv
module e3_payload_master
  import e3m_pkg::*;
#(
  parameter int        PAYLOAD_BITS = 1524,
  parameter int        FIFO_DEPTH   = 16,
  parameter e3m_byte_t FILL_BYTE    = 8'h55
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] byte_data,
  input  logic       byte_valid,
  output logic       byte_ready,
  input  logic       ovh_ind,
  output logic       ser_data,
  output logic       frame_ref
);
  logic      advance;
  logic      fifo_empty;
  logic      fifo_pop;
  e3m_byte_t fifo_data;

  assign advance = !ovh_ind;

  e3m_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_valid(byte_valid), .wr_data(byte_data), .wr_ready(byte_ready),
    .rd_en(fifo_pop), .rd_data(fifo_data), .empty(fifo_empty)
  );

  e3m_serializer #(.FILL_BYTE(FILL_BYTE)) u_ser (
    .clk(clk), .rst(rst), .advance(advance),
    .src_empty(fifo_empty), .src_data(fifo_data),
    .src_pop(fifo_pop), .ser_out(ser_data)
  );

  e3m_frame_ctr #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_frm (
    .clk(clk), .rst(rst), .advance(advance), .frame_ref(frame_ref)
  );
endmodule

// File: rtl/e3m_checker.sv
module e3m_checker #(
  parameter int PAYLOAD_BITS = 1524
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] byte_data,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic       ovh_ind,
  input logic       ser_data,
  input logic       frame_ref
);
  localparam int GW = $clog2(PAYLOAD_BITS + 2) + 1;

  logic [GW-1:0] gap;
  logic          seen_ref;
  logic          just_rel;

  always_ff @(posedge clk) begin
    just_rel <= rst;
    if (rst) begin
      gap      <= '0;
      seen_ref <= 1'b0;
    end else begin
      if (frame_ref) seen_ref <= 1'b1;
      gap <= frame_ref ? GW'(!ovh_ind) : gap + GW'(!ovh_ind);
    end
  end

  // R3: an overhead sample freezes the bit and suppresses the strobe
  a_r3_hold_on_ovh: assert property (@(posedge clk) disable iff (rst)
    ovh_ind |=> ($stable(ser_data) && !frame_ref));

  // R4: strobe lasts one clock
  a_r4_ref_single: assert property (@(posedge clk) disable iff (rst)
    frame_ref |=> !frame_ref);

  // R4: first issue edge after reset release raises the strobe
  a_r4_first_ref: assert property (@(posedge clk) disable iff (rst)
    (just_rel && !ovh_ind) |=> frame_ref);

  // R5: strobes are PAYLOAD_BITS issue edges apart
  a_r5_ref_spacing: assert property (@(posedge clk) disable iff (rst)
    (frame_ref && seen_ref) |-> (gap == GW'(PAYLOAD_BITS)));

  // R6: a refused offer is not taken, so the FIFO stays full
  a_r6_full_until_read: assert property (@(posedge clk) disable iff (rst)
    (!byte_ready && ovh_ind) |=> !byte_ready);
endmodule

bind e3_payload_master e3m_checker #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_chk (
  .clk(clk), .rst(rst), .byte_data(byte_data), .byte_valid(byte_valid),
  .byte_ready(byte_ready), .ovh_ind(ovh_ind), .ser_data(ser_data),
  .frame_ref(frame_ref)
);

// File: tb/e3_payload_master_test.sv
module e3_payload_master_test;
  localparam int PB    = 20;
  localparam int DEPTH = 4;
  localparam logic [7:0] FILL = 8'hC3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] byte_data = '0;
  logic       byte_valid = 1'b0;
  logic       byte_ready;
  logic       ovh_ind = 1'b0;
  logic       ser_data;
  logic       frame_ref;

  int tests = 0;
  int fails = 0;

  e3_payload_master #(.PAYLOAD_BITS(PB), .FIFO_DEPTH(DEPTH), .FILL_BYTE(FILL)) uut (
    .clk(clk), .rst(rst), .byte_data(byte_data), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .ovh_ind(ovh_ind), .ser_data(ser_data),
    .frame_ref(frame_ref)
  );

  always #4 clk = ~clk;

  // scoreboard state
  logic [7:0] q[$];
  int         m_pos, m_left;
  logic [7:0] m_sh;
  logic       m_ser, m_fill;
  logic [7:0] next_byte = 8'h10;
  string      ser_tag = "R2";
  string      ref_tag = "R4";

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    q.delete();
    m_pos = 0; m_left = 0; m_sh = '0; m_ser = 1'b0; m_fill = 1'b0;
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1; ovh_ind = 1'b0; byte_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1", ser_data, 1'b0, "ser_data in reset");
      check("R1", frame_ref, 1'b0, "frame_ref in reset");
      check("R1", byte_ready, 1'b1, "byte_ready in reset");
    end
    model_reset();
    rst = 1'b0;
  endtask

  // driver + scoreboard: one clock, called at a falling edge
  task automatic step(input logic ovh, input logic vld);
    logic       acc;
    logic       exp_ref;
    logic [7:0] b;
    ovh_ind = ovh; byte_valid = vld; byte_data = next_byte;
    #1;
    acc = vld && byte_ready;
    @(posedge clk);
    exp_ref = 1'b0;
    if (!ovh) begin
      if (m_left == 0) begin
        if (q.size() > 0) begin b = q.pop_front(); m_fill = 1'b0; end
        else begin b = FILL; m_fill = 1'b1; end
        m_ser = b[7]; m_sh = {b[6:0], 1'b0}; m_left = 7;
      end else begin
        m_ser = m_sh[7]; m_sh = {m_sh[6:0], 1'b0}; m_left--;
      end
      exp_ref = (m_pos == 0);
      m_pos = (m_pos == PB - 1) ? 0 : m_pos + 1;
    end
    if (acc) begin q.push_back(next_byte); next_byte++; end
    @(negedge clk);
    if (ovh) begin
      check("R3", ser_data, m_ser, "ser_data held under overhead");
      check("R3", frame_ref, 1'b0, "frame_ref under overhead");
    end else begin
      check(m_fill ? "R7" : ser_tag, ser_data, m_ser, "ser_data");
      check(ref_tag, frame_ref, exp_ref, "frame_ref");
    end
    check("R6", byte_ready, (q.size() < DEPTH), "byte_ready");
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset(3);                               // R1

    // R4, R7: first edge after release strobes, FIFO still empty -> fill byte
    ref_tag = "R4";
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1);

    // R2, R5, R8: continuous stream over several short frames, FIFO fills (R6)
    ser_tag = "R8"; ref_tag = "R5";
    for (int i = 0; i < 5 * PB; i++) step(1'b0, 1'b1);

    // R3: single overhead periods spread through frames
    ser_tag = "R2";
    for (int i = 0; i < 3 * PB; i++) step((i % 7) == 3, 1'b1);

    // R3: 16-period overhead run, then resume
    for (int i = 0; i < 16; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 2 * PB; i++) step(1'b0, 1'b1);

    // R7: source runs dry, fill bytes follow stored bytes
    for (int i = 0; i < 6 * PB; i++) step((i % 11) == 5, 1'b0);

    // R8: sparse offers with overhead mixed in
    ser_tag = "R8";
    for (int i = 0; i < 4 * PB; i++) step((i % 9) == 0, (i % 3) == 0);

    // R1, R4: reset mid-frame, overhead at the first edge delays the first strobe
    do_reset(2);
    ref_tag = "R4";
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    for (int i = 0; i < 3 * PB; i++) step(1'b0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule